// File: doc/BRIEF.md
# IO Rail Power Detect Controller

This block sequences the power-detect cells and pad-disable bits that belong to a set of IO supply rails. A fixed rail map, given as parameters, ties every map entry to a rail address, to one pad-disable bit and, when the entry has a detect cell, to one detect-enable bit. A rail event carries a rail address and a direction. The controller looks up every entry sharing that address and then acts in one of two ways. For a rail turning off, the matching pads are disabled at once. For a rail turning on, the detect cells are armed and their latches preset high. The controller then waits for the regulator to report that the rail is stable. After that it opens the latches, captures them, switches the cells off and enables the pads again.

A start-up request runs the capture part on its own. It records which rails are already powered, and then disables the pads of the rails that were reported unpowered. While a sequence is running, the controller reports busy and ignores any new events.

Top module: `io_rail_pwrdet_ctrl`

## Requirements
- R1: After reset, `det_en`, `latch_ctl`, `latch_preset`, `no_io_pwr` and `busy` are all zero.
- R2: The default map has ten entries. Entry i drives bit i of both the pad-disable mask and the detect-enable mask. Entry 9 has no detect cell, so its detect bit is always zero.
- R3: A lookup ORs together the masks of all entries with the matching address. The default addresses of entries 0 to 9 are 1,1,2,3,4,4,6,7,8,9, so address 4 selects bits 4 and 5.
- R4: An event on an address that matches no entry changes no output and leaves `busy` low.
- R5: A rail-on event with a non-zero detect mask puts that mask on `det_en` in the following cycle. `latch_preset` then pulses high for exactly one cycle. If the detect mask is zero, both of these steps are skipped and `det_en` stays zero.
- R6: Once armed, the controller holds `latch_ctl` low until `stable_done` is seen. It then raises `latch_ctl` for exactly one cycle and lowers it. One cycle after that, `det_en` returns to zero.
- R7: A rail-off event sets the rail's pad-disable bits in `no_io_pwr` one cycle later. No other bits change, and `busy` stays low.
- R8: At the end of a rail-on sequence, the rail's bits in `no_io_pwr` are cleared and all other bits are kept.
- R9: `init_req` causes one `latch_ctl` pulse and leaves the detect cells disabled. After that, the bits given on `init_off_mask` are set in `no_io_pwr`.
- R10: While `busy` is high, events and `init_req` are ignored. When `busy` is low, `latch_ctl` and `latch_preset` are low.
- R11: After a `latch_preset` pulse, at least `PRESET_GAP` cycles pass before `latch_ctl` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Rail event strobe |
| evt_on | input | 1 | 1 = rail turning on, 0 = rail turning off |
| evt_addr | input | ADDR_W | Rail address of the event |
| init_req | input | 1 | Start-up capture request |
| init_off_mask | input | NUM_RAILS | Rails reported at zero voltage at start-up |
| stable_done | input | 1 | Regulator reports the rail has settled |
| det_en | output | NUM_RAILS | Detect-cell enables |
| latch_ctl | output | 1 | Detect latch control (1 = pass-through, 0 = hold) |
| latch_preset | output | 1 | One-cycle strobe presetting the latches high |
| no_io_pwr | output | NUM_RAILS | Pad-disable mask |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench keeps the default ten-entry map. In that map, two addresses are shared by two entries and the last entry has no detect cell. This exercises combined lookups, the path that skips the preset, and unmapped addresses. `PRESET_GAP` is set to 2 so the preset-to-latch spacing can be measured as an exact cycle count. The regulator's stable signal is held back for several cycles in one case and is already high in another. This covers both a long wait in the armed state and the shortest possible route to the latch pulse.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRESET,
      ST_GAP,
      ST_ARM,
      ST_CAPTURE,
      ST_FINISH
   } rpd_state_e;
endpackage

// File: rtl/rpd_rail_map.sv
module rpd_rail_map #(
   parameter int unsigned NUM_RAILS = 10,
   parameter int unsigned ADDR_W    = 4,
   parameter logic [NUM_RAILS*ADDR_W-1:0] ADDR_MAP = '0,
   parameter logic [NUM_RAILS-1:0]        CELL_MAP = '0
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_RAILS-1:0] det_mask,
   output logic [NUM_RAILS-1:0] dis_mask,
   output logic                 mapped
);
   logic [NUM_RAILS-1:0] hit;

   // each entry owns bit i of both masks; sharing an address merges bits
   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_entry
      assign hit[i]      = (ADDR_MAP[i*ADDR_W +: ADDR_W] == addr);
      assign dis_mask[i] = hit[i];
      if (CELL_MAP[i]) begin : g_cell
         assign det_mask[i] = hit[i];
      end else begin : g_nocell
         assign det_mask[i] = 1'b0;
      end
   end

   assign mapped = (|det_mask) | (|dis_mask);
endmodule

// File: rtl/rpd_pad_mask.sv
module rpd_pad_mask #(
   parameter int unsigned NUM_RAILS = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] set_bits,
   input  logic [NUM_RAILS-1:0] clr_bits,
   output logic [NUM_RAILS-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q & ~clr_bits) | set_bits;
   end
endmodule

// File: rtl/rpd_sequencer.sv
module rpd_sequencer
   import rpd_pkg::*;
#(
   parameter int unsigned NUM_RAILS  = 10,
   parameter int unsigned PRESET_GAP = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic                 evt_on,
   input  logic [NUM_RAILS-1:0] det_mask,
   input  logic [NUM_RAILS-1:0] dis_mask,
   input  logic                 mapped,
   input  logic                 init_req,
   input  logic [NUM_RAILS-1:0] init_off,
   input  logic                 stable_done,
   output logic [NUM_RAILS-1:0] det_en,
   output logic                 latch_ctl,
   output logic                 latch_preset,
   output logic                 busy,
   output logic [NUM_RAILS-1:0] pad_set,
   output logic [NUM_RAILS-1:0] pad_clr
);
   localparam int unsigned GW = (PRESET_GAP > 1) ? $clog2(PRESET_GAP) : 1;

   rpd_state_e           st;
   logic [GW-1:0]        gcnt;
   logic [NUM_RAILS-1:0] pend_dis;
   logic [NUM_RAILS-1:0] pend_off;
   logic                 off_evt;

   assign off_evt = (st == ST_IDLE) && !init_req && evt_valid && !evt_on && mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         gcnt         <= '0;
         det_en       <= '0;
         latch_ctl    <= 1'b0;
         latch_preset <= 1'b0;
         pend_dis     <= '0;
         pend_off     <= '0;
      end else begin
         latch_preset <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (init_req) begin
                  pend_dis  <= '0;
                  pend_off  <= init_off;
                  latch_ctl <= 1'b1;
                  st        <= ST_CAPTURE;
               end else if (evt_valid && evt_on && mapped) begin
                  pend_dis <= dis_mask;
                  pend_off <= '0;
                  if (|det_mask) begin
                     det_en <= det_mask;
                     st     <= ST_PRESET;
                  end else begin
                     st <= ST_ARM;
                  end
               end
            end
            ST_PRESET: begin
               latch_preset <= 1'b1;
               gcnt         <= GW'(PRESET_GAP - 1);
               st           <= ST_GAP;
            end
            ST_GAP: begin
               if (gcnt == '0) st <= ST_ARM;
               else            gcnt <= gcnt - 1'b1;
            end
            ST_ARM: begin
               if (stable_done) begin
                  latch_ctl <= 1'b1;
                  st        <= ST_CAPTURE;
               end
            end
            ST_CAPTURE: begin
               latch_ctl <= 1'b0;
               st        <= ST_FINISH;
            end
            ST_FINISH: begin
               det_en   <= '0;
               pend_dis <= '0;
               pend_off <= '0;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign pad_clr = (st == ST_FINISH) ? pend_dis : '0;
   assign pad_set = (st == ST_FINISH) ? pend_off : (off_evt ? dis_mask : '0);
endmodule

// File: rtl/io_rail_pwrdet_ctrl.sv
module io_rail_pwrdet_ctrl #(
   parameter int unsigned NUM_RAILS  = 10,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned PRESET_GAP = 4,
   parameter logic [NUM_RAILS*ADDR_W-1:0] ADDR_MAP = 40'h98764_43211,
   parameter logic [NUM_RAILS-1:0]        CELL_MAP = 10'h1FF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic                 evt_on,
   input  logic [ADDR_W-1:0]    evt_addr,
   input  logic                 init_req,
   input  logic [NUM_RAILS-1:0] init_off_mask,
   input  logic                 stable_done,
   output logic [NUM_RAILS-1:0] det_en,
   output logic                 latch_ctl,
   output logic                 latch_preset,
   output logic [NUM_RAILS-1:0] no_io_pwr,
   output logic                 busy
);
   if (NUM_RAILS < 1)  begin : g_bad_rails  $error("NUM_RAILS must be at least 1");  end
   if (ADDR_W < 1)     begin : g_bad_addr   $error("ADDR_W must be at least 1");     end
   if (PRESET_GAP < 1) begin : g_bad_gap    $error("PRESET_GAP must be at least 1"); end

   logic [NUM_RAILS-1:0] det_mask, dis_mask, pad_set, pad_clr;
   logic                 mapped;

   rpd_rail_map #(
      .NUM_RAILS(NUM_RAILS), .ADDR_W(ADDR_W),
      .ADDR_MAP(ADDR_MAP), .CELL_MAP(CELL_MAP)
   ) u_map (
      .addr(evt_addr), .det_mask(det_mask), .dis_mask(dis_mask), .mapped(mapped)
   );

   rpd_sequencer #(
      .NUM_RAILS(NUM_RAILS), .PRESET_GAP(PRESET_GAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_on(evt_on),
      .det_mask(det_mask), .dis_mask(dis_mask), .mapped(mapped),
      .init_req(init_req), .init_off(init_off_mask),
      .stable_done(stable_done),
      .det_en(det_en), .latch_ctl(latch_ctl), .latch_preset(latch_preset),
      .busy(busy), .pad_set(pad_set), .pad_clr(pad_clr)
   );

   rpd_pad_mask #(.NUM_RAILS(NUM_RAILS)) u_pad (
      .clk(clk), .rst_n(rst_n),
      .set_bits(pad_set), .clr_bits(pad_clr), .mask_q(no_io_pwr)
   );
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
   parameter int unsigned NUM_RAILS  = 10,
   parameter int unsigned PRESET_GAP = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 evt_valid,
   input logic                 evt_on,
   input logic                 init_req,
   input logic [NUM_RAILS-1:0] det_en,
   input logic                 latch_ctl,
   input logic                 latch_preset,
   input logic [NUM_RAILS-1:0] no_io_pwr,
   input logic                 busy
);
   localparam int unsigned CW = $clog2(PRESET_GAP + 2);
   logic [CW-1:0] since_preset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           since_preset <= CW'(PRESET_GAP);
      else if (latch_preset)                since_preset <= '0;
      else if (since_preset < CW'(PRESET_GAP)) since_preset <= since_preset + 1'b1;
   end

   assert_preset_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      latch_preset |=> !latch_preset);

   assert_latch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_ctl) |=> !latch_ctl);

   assert_cells_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_ctl) |=> (det_en == '0));

   assert_off_only_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && evt_valid && !evt_on && !init_req) |=> (($past(no_io_pwr) & ~no_io_pwr) == '0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!latch_ctl && !latch_preset));

   assert_preset_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_ctl) |-> (since_preset >= CW'(PRESET_GAP)));
endmodule

bind io_rail_pwrdet_ctrl rpd_checker #(
   .NUM_RAILS(NUM_RAILS), .PRESET_GAP(PRESET_GAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_on(evt_on),
   .init_req(init_req), .det_en(det_en), .latch_ctl(latch_ctl),
   .latch_preset(latch_preset), .no_io_pwr(no_io_pwr), .busy(busy)
);

// File: tb/sim_io_rail_pwrdet_ctrl.sv
module sim_io_rail_pwrdet_ctrl;
   localparam int N   = 10;
   localparam int AW  = 4;
   localparam int GAP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0, evt_on = 1'b0, init_req = 1'b0, stable_done = 1'b0;
   logic [AW-1:0] evt_addr = '0;
   logic [N-1:0]  init_off_mask = '0;
   logic [N-1:0]  det_en, no_io_pwr;
   logic          latch_ctl, latch_preset, busy;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [N-1:0] exp_pad = '0;

   always #2ns clk = ~clk;

   io_rail_pwrdet_ctrl #(.NUM_RAILS(N), .ADDR_W(AW), .PRESET_GAP(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_on(evt_on),
      .evt_addr(evt_addr), .init_req(init_req), .init_off_mask(init_off_mask),
      .stable_done(stable_done), .det_en(det_en), .latch_ctl(latch_ctl),
      .latch_preset(latch_preset), .no_io_pwr(no_io_pwr), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         summary();
      end
   end

   task automatic send(input logic on, input logic [AW-1:0] a);
      evt_valid = 1'b1; evt_on = on; evt_addr = a;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 det_en", det_en, 0);
      chk("R1 latch_ctl", latch_ctl, 0);
      chk("R1 latch_preset", latch_preset, 0);
      chk("R1 no_io_pwr", no_io_pwr, 0);
      chk("R1 busy", busy, 0);
   endtask

   task automatic t_init();
      init_off_mask = 10'h204;
      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      chk("R9 latch open", latch_ctl, 1);
      chk("R9 busy", busy, 1);
      @(negedge clk);
      chk("R9 latch closed", latch_ctl, 0);
      @(negedge clk);
      exp_pad = 10'h204;
      chk("R9 pads off", no_io_pwr, exp_pad);
      chk("R9 cells off", det_en, 0);
      chk("R9 idle", busy, 0);
   endtask

   task automatic t_off_shared();
      send(1'b0, 4'd4);
      exp_pad |= 10'h030;
      chk("R7 R3 shared off", no_io_pwr, exp_pad);
      chk("R7 no busy", busy, 0);
   endtask

   task automatic t_unmapped();
      send(1'b0, 4'd5);
      chk("R4 off unmapped", no_io_pwr, exp_pad);
      send(1'b1, 4'd0);
      chk("R4 on unmapped busy", busy, 0);
      chk("R4 on unmapped det", det_en, 0);
      @(negedge clk);
      chk("R4 no preset", latch_preset, 0);
   endtask

   task automatic t_on_shared();
      send(1'b1, 4'd4);
      chk("R5 det armed", det_en, 10'h030);
      chk("R10 busy", busy, 1);
      chk("R5 preset not yet", latch_preset, 0);
      @(negedge clk);
      chk("R5 preset strobe", latch_preset, 1);
      @(negedge clk);
      chk("R5 preset one cycle", latch_preset, 0);
      repeat (5) @(negedge clk);
      chk("R6 waits for stable", latch_ctl, 0);
      chk("R6 cells still armed", det_en, 10'h030);
      send(1'b0, 4'd1);
      @(negedge clk);
      chk("R10 event ignored", no_io_pwr, exp_pad);
      stable_done = 1'b1;
      @(negedge clk);
      stable_done = 1'b0;
      chk("R6 pass-through", latch_ctl, 1);
      @(negedge clk);
      chk("R6 capture", latch_ctl, 0);
      chk("R6 cells held", det_en, 10'h030);
      @(negedge clk);
      chk("R6 cells off", det_en, 0);
      exp_pad &= ~10'h030;
      chk("R8 pads on, rest kept", no_io_pwr, exp_pad);
      chk("R8 idle", busy, 0);
   endtask

   task automatic t_on_nocell();
      int seen = 0;
      send(1'b1, 4'd9);
      chk("R2 busy", busy, 1);
      repeat (4) begin
         if (latch_preset) seen++;
         chk("R2 no detect bit", det_en, 0);
         @(negedge clk);
      end
      chk("R5 preset skipped", seen, 0);
      stable_done = 1'b1;
      @(negedge clk);
      stable_done = 1'b0;
      chk("R2 latch pulse", latch_ctl, 1);
      repeat (2) @(negedge clk);
      exp_pad &= ~10'h200;
      chk("R2 pad bit 9 on", no_io_pwr, exp_pad);
   endtask

   task automatic t_gap();
      int n = 0;
      stable_done = 1'b1;
      send(1'b1, 4'd2);
      chk("R2 R3 det bit 2", det_en, 10'h004);
      @(negedge clk);
      chk("R11 preset", latch_preset, 1);
      while (!latch_ctl && n < 50) begin
         @(negedge clk);
         n++;
      end
      stable_done = 1'b0;
      chk("R11 preset to latch cycles", n, GAP + 1);
      repeat (2) @(negedge clk);
      exp_pad &= ~10'h004;
      chk("R8 pad bit 2 on", no_io_pwr, exp_pad);
   endtask

   task automatic t_init_while_busy();
      send(1'b1, 4'd1);
      chk("R3 det bits 0,1", det_en, 10'h003);
      init_off_mask = 10'h3FF;
      init_req = 1'b1;
      repeat (3) @(negedge clk);
      init_req = 1'b0;
      chk("R10 init ignored", no_io_pwr, exp_pad);
      chk("R10 still armed", det_en, 10'h003);
      stable_done = 1'b1;
      @(negedge clk);
      stable_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 idle pads", no_io_pwr, exp_pad);
      chk("R10 idle", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init();
      t_off_shared();
      t_unmapped();
      t_on_shared();
      t_on_nocell();
      t_gap();
      t_init_while_busy();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule